// File: doc/BRIEF.md
# Timed Page Programming Engine

This block sits behind a serial memory interface and handles the page-write command. A decoder that sits in front of it signals the start of a write command and passes the start address. It then hands over each received data byte as a one-cycle strobe. The engine places every byte in a local page buffer. The buffer holds one page of 128 bytes. The byte's position in the buffer comes from the low address bits, which step by one and wrap, while the upper address bits stay fixed for the whole command.

When chip select returns high, the front end reports the event and also says whether it landed on a byte boundary. A separate protection unit supplies a single permission flag. That flag already combines the write-enable latch with the block-protection verdict for the page. The engine starts its internal programming cycle only when four things hold together: the rise is on a boundary, a full page or more has arrived, the flag allows it, and a command is open. The programming cycle lasts a fixed number of clock cycles. It first copies the buffer into the array, one byte per cycle, and then waits out the rest of the cycle with busy held high. In the final busy cycle it pulses a request to clear the write-enable latch. While busy, it ignores new commands, bytes and chip-select events.

Top module: `page_write_engine`

## Requirements
- R1: After reset, busy, mem_we and wel_clr are all 0.
- R2: The n-th byte (counting from 0) after cmd_start goes to page offset (cmd_addr[6:0] + n) mod 128. The upper cmd_addr bits [AW-1:7] form mem_addr[AW-1:7] for every array write of that page.
- R3: When more than 128 bytes arrive, the offset wraps. A later byte replaces an earlier byte at the same offset, and the last byte written to an offset is the one programmed.
- R4: busy rises only in the cycle after a cs_rise strobe, and only if, in that cycle, on_boundary=1, permit=1, a command is open and at least 128 bytes have arrived. If any of these is missing, busy and mem_we stay 0.
- R5: Once started, busy stays 1 for exactly WC_CYCLES clock cycles.
- R6: In the first 128 busy cycles, mem_we=1 and the offsets run 0,1,...,127 in order, with mem_wdata equal to the buffered byte for that offset. In the remaining busy cycles, mem_we=0. mem_we is never 1 outside busy.
- R7: wel_clr is 1 only in the last busy cycle.
- R8: While busy, cmd_start, byte_stb and cs_rise have no effect. The page being copied does not change, and no second cycle follows unless a new command is sent after busy falls.
- R9: A byte_stb in the same cycle as cs_rise counts as a received byte, and it can be the byte that completes the page.
- R10: A cs_rise closes the command whether or not it commits. Bytes and a cs_rise that arrive without a new cmd_start start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Write command decoded; latches cmd_addr |
| cmd_addr | input | AW | Start byte address |
| byte_stb | input | 1 | One received data byte |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Chip select went high |
| on_boundary | input | 1 | The rise came right after a complete byte |
| permit | input | 1 | Write enabled and page not protected |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | AW | Array byte address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Programming cycle in progress |
| wel_clr | output | 1 | Clear the write-enable latch |

## Verification
Two events can land in the same cycle. The last data strobe can coincide with the chip-select rise, which has to both complete the page and commit it. A new command, with its bytes and rise, can arrive while the copy phase is still reading the buffer. The bench provokes the first case with a directed run of exactly 127 separate strobes followed by a 128th strobe driven together with cs_rise, and it expects a full, correct copy. It provokes the second case by pushing a complete foreign command during busy. It judges that case by comparing every copied byte against the original page model and by confirming that no second cycle appears afterwards.

// File: rtl/page_write_engine.sv
module page_write_engine #(
  parameter int AW        = 17,
  parameter int PB        = 7,
  parameter int WC_CYCLES = 250000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [AW-1:0] cmd_addr,
  input  logic          byte_stb,
  input  logic [7:0]    byte_data,
  input  logic          cs_rise,
  input  logic          on_boundary,
  input  logic          permit,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          busy,
  output logic          wel_clr
);
  localparam int PAGE = 1 << PB;
  localparam int TW   = $clog2(WC_CYCLES);

  logic [7:0]       pbuf [PAGE];
  logic             open_cmd;
  logic [PB-1:0]    ptr;
  logic [AW-PB-1:0] upper;
  logic [PB:0]      cnt;
  logic [TW-1:0]    timer;

  wire take    = open_cmd & byte_stb;
  wire full    = cnt[PB] | (take & (cnt == (PB+1)'(PAGE-1)));
  wire commit  = open_cmd & cs_rise & on_boundary & permit & full;
  wire last    = busy & (timer == TW'(WC_CYCLES-1));

  always_ff @(posedge clk) begin
    if (take) pbuf[ptr] <= byte_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_cmd <= 1'b0;
      ptr      <= '0;
      upper    <= '0;
      cnt      <= '0;
      busy     <= 1'b0;
      timer    <= '0;
    end else if (busy) begin
      timer <= timer + 1'b1;
      if (last) busy <= 1'b0;
    end else if (cs_rise) begin
      open_cmd <= 1'b0;
      busy     <= commit;
      timer    <= '0;
    end else if (cmd_start) begin
      open_cmd <= 1'b1;
      ptr      <= cmd_addr[PB-1:0];
      upper    <= cmd_addr[AW-1:PB];
      cnt      <= '0;
    end else if (take) begin
      ptr <= ptr + 1'b1;
      if (!cnt[PB]) cnt <= cnt + 1'b1;
    end
  end

  assign mem_we    = busy & (timer < TW'(PAGE));
  assign mem_addr  = {upper, timer[PB-1:0]};
  assign mem_wdata = pbuf[timer[PB-1:0]];
  assign wel_clr   = last;
endmodule

// File: rtl/page_write_engine_chk.sv
module page_write_engine_chk #(
  parameter int AW = 17,
  parameter int PB = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_rise,
  input logic          on_boundary,
  input logic          permit,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          wel_clr
);
  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R6

  AST_WEL_CLR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !busy); // R7

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise & on_boundary & permit)); // R4

  AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[PB-1:0] == $past(mem_addr[PB-1:0]) + 1'b1)); // R6

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr[AW-1:PB])); // R2
endmodule

bind page_write_engine page_write_engine_chk #(.AW(AW), .PB(PB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .on_boundary(on_boundary),
  .permit(permit), .mem_we(mem_we), .mem_addr(mem_addr), .busy(busy),
  .wel_clr(wel_clr)
);

// File: tb/test_page_write_engine.sv
module test_page_write_engine;
  localparam int AW = 17;
  localparam int PB = 7;
  localparam int WC = 200;
  localparam int PAGE = 1 << PB;

  logic clk = 0, rst_n = 0;
  logic cmd_start = 0, byte_stb = 0, cs_rise = 0, on_boundary = 0, permit = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] byte_data = '0;
  logic mem_we, busy, wel_clr;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;

  int checks = 0, errors = 0;
  logic [7:0] exp_buf [PAGE];
  logic [AW-PB-1:0] exp_up;
  logic [PB-1:0] exp_ptr;

  always #5 clk = ~clk;

  page_write_engine #(.AW(AW), .PB(PB), .WC_CYCLES(WC)) i_page_write_engine (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [PB-1:0] next_off(input logic [PB-1:0] p);
    return p + 1'b1;
  endfunction

  task automatic start_cmd(input logic [AW-1:0] a);
    cmd_addr = a; cmd_start = 1;
    exp_up = a[AW-1:PB]; exp_ptr = a[PB-1:0];
    @(negedge clk); cmd_start = 0;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit with_rise, input bit bnd, input bit perm);
    byte_stb = 1; byte_data = d;
    if (with_rise) begin cs_rise = 1; on_boundary = bnd; permit = perm; end
    exp_buf[exp_ptr] = d; exp_ptr = next_off(exp_ptr);
    @(negedge clk); byte_stb = 0; cs_rise = 0;
  endtask

  task automatic rise(input bit bnd, input bit perm);
    cs_rise = 1; on_boundary = bnd; permit = perm;
    @(negedge clk); cs_rise = 0;
  endtask

  // called at the negedge right after the committing edge
  task automatic watch_cycle(input string tag);
    for (int k = 0; k < WC; k++) begin
      if (!busy) begin chk(0, {tag, " R5 busy"}, busy, 1); end
      if (k < PAGE) begin
        chk(mem_we && mem_addr == {exp_up, PB'(k)} && mem_wdata == exp_buf[k],
            {tag, " R6/R2/R3 copy"}, {mem_we, mem_addr, mem_wdata}, {1'b1, exp_up, PB'(k), exp_buf[k]});
      end else if (mem_we) chk(0, {tag, " R6 idle we"}, mem_we, 0);
      if (wel_clr != (k == WC-1)) chk(0, {tag, " R7 wel_clr"}, wel_clr, k == WC-1);
      @(negedge clk);
    end
    chk(!busy && !mem_we, {tag, " R5 end"}, busy, 0);
  endtask

  task automatic quiet(input int n, input string tag);
    bit bad = 0;
    for (int k = 0; k < n; k++) begin
      if (busy || mem_we) bad = 1;
      @(negedge clk);
    end
    chk(!bad, tag, bad, 0);
  endtask

  task automatic disturb();
    repeat (5) @(negedge clk);
    cmd_addr = 17'h1_2345; cmd_start = 1; @(negedge clk); cmd_start = 0;
    for (int i = 0; i < 130; i++) begin
      byte_stb = 1; byte_data = 8'($urandom); @(negedge clk); byte_stb = 0;
    end
    cs_rise = 1; on_boundary = 1; permit = 1; @(negedge clk); cs_rise = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    chk(!busy && !mem_we && !wel_clr, "R1 reset", {busy, mem_we, wel_clr}, 0);
    rst_n = 1;
    @(negedge clk);

    // directed: aligned page, exactly 128 bytes
    start_cmd(17'h0_0080);
    for (int i = 0; i < PAGE; i++) send_byte(8'($urandom), 0, 0, 0);
    rise(1, 1);
    watch_cycle("aligned R4");

    // R9: last byte coincident with rise
    start_cmd(17'h1_F85);
    for (int i = 0; i < PAGE-1; i++) send_byte(8'($urandom), 0, 0, 0);
    send_byte(8'h5A, 1, 1, 1);
    watch_cycle("coincident R9");

    // R4 negatives
    start_cmd(17'h0_0200);
    for (int i = 0; i < PAGE-1; i++) send_byte(8'($urandom), 0, 0, 0);
    rise(1, 1);
    quiet(20, "R4 short page");
    start_cmd(17'h0_0200);
    for (int i = 0; i < PAGE; i++) send_byte(8'($urandom), 0, 0, 0);
    rise(0, 1);
    quiet(20, "R4 mid-byte rise");
    start_cmd(17'h0_0200);
    for (int i = 0; i < PAGE; i++) send_byte(8'($urandom), 0, 0, 0);
    rise(1, 0);
    quiet(20, "R4 no permit");

    // R10: rise after closed command, and bytes without a command
    rise(1, 1);
    quiet(20, "R10 rise without command");
    for (int i = 0; i < PAGE; i++) send_byte(8'($urandom), 0, 0, 0);
    rise(1, 1);
    quiet(20, "R10 bytes without command");

    // R8: disturbance during busy
    start_cmd(17'h0_4411);
    for (int i = 0; i < PAGE; i++) send_byte(8'($urandom), 0, 0, 0);
    rise(1, 1);
    fork
      watch_cycle("disturb R8");
      disturb();
    join
    quiet(20, "R8 no second cycle");

    // random rounds with wrap (R3)
    for (int r = 0; r < 8; r++) begin
      int n;
      bit bnd, perm;
      n = PAGE + int'($urandom_range(0, 90));
      bnd = ($urandom_range(0, 3) != 0);
      perm = ($urandom_range(0, 3) != 0);
      start_cmd(AW'($urandom));
      for (int i = 0; i < n; i++) send_byte(8'($urandom), 0, 0, 0);
      rise(bnd, perm);
      if (bnd && perm) watch_cycle("random R3");
      else quiet(20, "random R4 refused");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule